// File: doc/BRIEF.md
# Timer Event Flags with Read-Arm Clear

This block is a 16-bit up-counter with a settable terminal value. It also keeps one sticky flag for counter wrap and one sticky flag for each of a few event channels. The channel events come in from outside as one-cycle pulses, standing in for capture or compare hardware. Each flag has its own enable bit. The single interrupt line is a level and stays high while any enabled flag is set. Software can poll a flag whatever its enable holds.

A flag goes back to zero only through a handshake on the register port. Software first reads the status register while the flag is set, which arms that flag. A later write with a 0 in that bit position then clears it. If a fresh event for the same flag lands before the clearing write, the arming is cancelled and the flag stays set. An event that software has not yet seen is therefore never erased.

Top module: `timer_flags`

## Requirements
- R1: After reset, every flag, arm bit, enable bit, the terminal value and the counter read 0, and `irq` is low.
- R2: The counter adds one on every clock. With a nonzero terminal value, the clock edge that finds the counter equal to that value loads 0 and sets the wrap flag (status bit 0). At a count of 0xFFFF the counter rolls to 0 without setting the flag unless 0xFFFF is the terminal value.
- R3: With a terminal value of 0, the counter runs free, and the edge that moves it from 0xFFFF to 0x0000 sets the wrap flag.
- R4: A one-cycle pulse on `chEvent[i]` sets status bit i+1 at the next clock edge, whatever the enables hold.
- R5: `irq` is high exactly while some status bit is 1 and the enable register (address 1) holds a 1 in the same bit position.
- R6: A read strobe at address 0 arms every flag that is set in that cycle. A later write strobe at address 0 with a 0 in an armed flag's bit position clears that flag and its arm.
- R7: A write of 0 to a flag bit that was not armed leaves the flag unchanged. A 1 in a written status bit never changes that flag.
- R8: An event for a flag that falls between its arming read and the zero write drops the arm. The flag reads 1 after that write, and also after a second zero write made without a new read.
- R9: When an event and a clearing zero write for the same flag fall in the same cycle, the flag stays 1 and its arm is dropped.
- R10: Each flag has its own arm. Clearing one armed flag leaves the other armed flags armed, so a later zero write still clears them without a new read.
- R11: Register map: address 0 is status, 1 is enable (bits 0..NUM_CH, upper bits read 0), 2 is the terminal value (read/write), and 3 is the counter, which is read-only; writes there are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| addr | input | 2 | Register select |
| rdEn | input | 1 | Read strobe, one cycle per access |
| wrEn | input | 1 | Write strobe, one cycle per access |
| wrData | input | 16 | Write data |
| rdData | output | 16 | Read data for `addr`, combinational |
| chEvent | input | NUM_CH | One-cycle channel event pulses |
| irq | output | 1 | Level interrupt, active high |

## Verification
The bench targets the arming race. It places an event between the arming read and the zero write, and also in the same cycle as the write. A design that keeps the arm through an event would erase an event software never saw. It also checks that a zero write with no read before it does nothing, and that clearing one flag leaves its neighbours' arms intact; a shared arm bit fails that check. The wrap is timed at both a small terminal value and the free-running 0xFFFF rollover, where an off-by-one compare shows up as a flag one cycle early or late.

// File: rtl/timer_flags_pkg.sv
package timer_flags_pkg;

  localparam logic [1:0] ADDR_STATUS  = 2'd0;
  localparam logic [1:0] ADDR_ENABLE  = 2'd1;
  localparam logic [1:0] ADDR_MODULO  = 2'd2;
  localparam logic [1:0] ADDR_COUNTER = 2'd3;

  // decoded register-port strobes handed from control to datapath
  typedef struct packed {
    logic rdStatus;
    logic wrStatus;
    logic wrEnable;
    logic wrModulo;
  } busStrobes_t;

endpackage

// File: rtl/tfl_control.sv
module tfl_control
  import timer_flags_pkg::*;
#(
  parameter int NUM_FLAGS = 4,
  parameter int DATA_W    = 16
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [1:0]           addr,
  input  logic                 rdEn,
  input  logic                 wrEn,
  input  logic [DATA_W-1:0]    wrData,
  input  logic [NUM_FLAGS-1:0] evt,
  output busStrobes_t          strb,
  output logic [NUM_FLAGS-1:0] flags,
  output logic [NUM_FLAGS-1:0] armed
);

  always_comb begin
    strb.rdStatus = rdEn && (addr == ADDR_STATUS);
    strb.wrStatus = wrEn && (addr == ADDR_STATUS);
    strb.wrEnable = wrEn && (addr == ADDR_ENABLE);
    strb.wrModulo = wrEn && (addr == ADDR_MODULO);
  end

  // per-flag set / arm / clear; an event always wins and cancels the arm
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flags <= '0;
      armed <= '0;
    end else begin
      for (int i = 0; i < NUM_FLAGS; i++) begin
        if (evt[i]) begin
          flags[i] <= 1'b1;
          armed[i] <= 1'b0;
        end else if (strb.wrStatus && !wrData[i] && armed[i]) begin
          flags[i] <= 1'b0;
          armed[i] <= 1'b0;
        end else if (strb.rdStatus && flags[i]) begin
          armed[i] <= 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/tfl_datapath.sv
module tfl_datapath
  import timer_flags_pkg::*;
#(
  parameter int NUM_FLAGS = 4,
  parameter int CNT_W     = 16
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  busStrobes_t          strb,
  input  logic [1:0]           addr,
  input  logic [CNT_W-1:0]     wrData,
  input  logic [NUM_FLAGS-1:0] flags,
  output logic                 wrapEvt,
  output logic [NUM_FLAGS-1:0] enables,
  output logic [CNT_W-1:0]     count,
  output logic [CNT_W-1:0]     rdData
);

  localparam int PAD_W = CNT_W - NUM_FLAGS;

  logic [CNT_W-1:0] modQ;
  logic [CNT_W-1:0] termVal;

  assign termVal = (modQ == '0) ? '1 : modQ;
  assign wrapEvt = (count == termVal);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count <= '0;
    end else if (wrapEvt) begin
      count <= '0;
    end else begin
      count <= count + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modQ    <= '0;
      enables <= '0;
    end else begin
      if (strb.wrModulo) modQ    <= wrData;
      if (strb.wrEnable) enables <= wrData[NUM_FLAGS-1:0];
    end
  end

  always_comb begin
    unique case (addr)
      ADDR_STATUS:  rdData = {{PAD_W{1'b0}}, flags};
      ADDR_ENABLE:  rdData = {{PAD_W{1'b0}}, enables};
      ADDR_MODULO:  rdData = modQ;
      default:      rdData = count;
    endcase
  end

endmodule

// File: rtl/timer_flags.sv
module timer_flags
  import timer_flags_pkg::*;
#(
  parameter int NUM_CH = 3,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        addr,
  input  logic              rdEn,
  input  logic              wrEn,
  input  logic [CNT_W-1:0]  wrData,
  output logic [CNT_W-1:0]  rdData,
  input  logic [NUM_CH-1:0] chEvent,
  output logic              irq
);

  localparam int NUM_FLAGS = NUM_CH + 1;

  busStrobes_t          strb;
  logic                 wrapEvt;
  logic [NUM_FLAGS-1:0] flags;
  logic [NUM_FLAGS-1:0] armed;
  logic [NUM_FLAGS-1:0] enables;
  logic [CNT_W-1:0]     count;
  logic [NUM_FLAGS-1:0] evt;

  assign evt = {chEvent, wrapEvt};

  tfl_control #(.NUM_FLAGS(NUM_FLAGS), .DATA_W(CNT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .addr(addr), .rdEn(rdEn), .wrEn(wrEn),
    .wrData(wrData), .evt(evt), .strb(strb), .flags(flags), .armed(armed)
  );

  tfl_datapath #(.NUM_FLAGS(NUM_FLAGS), .CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .addr(addr), .wrData(wrData),
    .flags(flags), .wrapEvt(wrapEvt), .enables(enables), .count(count),
    .rdData(rdData)
  );

  assign irq = |(flags & enables);

endmodule

// File: rtl/timer_flags_chk.sv
module timer_flags_chk #(
  parameter int NUM_CH = 3,
  parameter int CNT_W  = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic [1:0]        addr,
  input logic              rdEn,
  input logic [NUM_CH-1:0] chEvent,
  input logic              wrapEvt,
  input logic [NUM_CH:0]   flags,
  input logic [NUM_CH:0]   armed,
  input logic [CNT_W-1:0]  count
);

  // R2
  count_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && count != '0) |-> count == $past(count) + 1'b1);

  // R3
  wrap_sets_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrapEvt |=> flags[0]);

  for (genvar i = 0; i <= NUM_CH; i++) begin : g_flag
    // R6
    clear_needs_arm_chk: assert property (@(posedge clk) disable iff (!rstN)
      $fell(flags[i]) |-> $past(armed[i]));
    // R6
    arm_needs_read_chk: assert property (@(posedge clk) disable iff (!rstN)
      $rose(armed[i]) |-> $past(rdEn && addr == 2'd0 && flags[i]));
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    // R4
    event_sets_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
      chEvent[c] |=> flags[c+1]);
    // R9
    event_drops_arm_chk: assert property (@(posedge clk) disable iff (!rstN)
      chEvent[c] |=> !armed[c+1]);
  end

endmodule

bind timer_flags timer_flags_chk #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rstN(rstN), .addr(addr), .rdEn(rdEn), .chEvent(chEvent),
  .wrapEvt(wrapEvt), .flags(flags), .armed(armed), .count(count)
);

// File: tb/timer_flags_bench.sv
`timescale 1ns/1ps
module timer_flags_bench;

  localparam int NCH = 3;
  localparam int NF  = NCH + 1;

  logic           clk = 1'b0;
  logic           rstN = 1'b0;
  logic [1:0]     addr = '0;
  logic           rdEn = 1'b0;
  logic           wrEn = 1'b0;
  logic [15:0]    wrData = '0;
  logic [NCH-1:0] chEvent = '0;
  logic [15:0]    rdData;
  logic           irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  timer_flags #(.NUM_CH(NCH), .CNT_W(16)) u_timer_flags (
    .clk(clk), .rstN(rstN), .addr(addr), .rdEn(rdEn), .wrEn(wrEn),
    .wrData(wrData), .rdData(rdData), .chEvent(chEvent), .irq(irq)
  );

  // behavioural reference built from the requirements
  logic [NF-1:0] mFlags, mArm, mEn;
  logic [15:0]   mMod, mCnt;

  always @(posedge clk) begin
    if (!rstN) begin
      mFlags = '0; mArm = '0; mEn = '0; mMod = '0; mCnt = '0;
    end else begin
      logic [15:0] term;
      logic [NF-1:0] ev;
      term = (mMod == 0) ? 16'hFFFF : mMod;
      ev = {chEvent, (mCnt == term)};
      mCnt = (mCnt == term) ? 16'h0 : mCnt + 16'h1;
      for (int i = 0; i < NF; i++) begin
        if (ev[i]) begin mFlags[i] = 1'b1; mArm[i] = 1'b0; end
        else if (wrEn && addr == 2'd0 && !wrData[i] && mArm[i]) begin
          mFlags[i] = 1'b0; mArm[i] = 1'b0;
        end else if (rdEn && addr == 2'd0 && mFlags[i]) mArm[i] = 1'b1;
      end
      if (wrEn && addr == 2'd1) mEn = wrData[NF-1:0];
      if (wrEn && addr == 2'd2) mMod = wrData;
    end
  end

  function automatic logic [15:0] modelRead(input logic [1:0] a);
    case (a)
      2'd0: return 16'(mFlags);
      2'd1: return 16'(mEn);
      2'd2: return mMod;
      default: return mCnt;
    endcase
  endfunction

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cyc(input logic [1:0] a, input logic r, input logic w,
                     input logic [15:0] d, input logic [NCH-1:0] ev);
    @(negedge clk);
    addr = a; rdEn = r; wrEn = w; wrData = d; chEvent = ev;
  endtask

  task automatic look(input logic [1:0] a, output logic [15:0] v);
    cyc(a, 1'b0, 1'b0, 16'h0, '0);
    #1 v = rdData;
  endtask

  task automatic expectReg(input string tag, input logic [1:0] a, input logic [15:0] exp);
    logic [15:0] v;
    look(a, v);
    check(tag, v, exp);
  endtask

  task automatic doReset();
    cyc(2'd0, 1'b0, 1'b0, 16'h0, '0);
    rstN = 1'b0;
    cyc(2'd0, 1'b0, 1'b0, 16'h0, '0);
    cyc(2'd0, 1'b0, 1'b0, 16'h0, '0);
    rstN = 1'b1;
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=hung expected=finished");
    finishRun();
  end

  initial begin
    logic [15:0] v, prev;
    int loops;
    void'($urandom(32'h5eed1234));
    doReset();

    // R1 reset state
    expectReg("R1 status", 2'd0, 16'h0);
    check("R1 irq", 16'(irq), 16'h0);
    expectReg("R1 enable", 2'd1, 16'h0);
    expectReg("R1 modulo", 2'd2, 16'h0);
    look(2'd3, v);
    check("R1 counter", 16'(v < 16'd20), 16'h1);

    // R4 channel pulses set bit i+1
    cyc(2'd0, 0, 0, 16'h0, 3'b001);
    expectReg("R4 ch0", 2'd0, 16'h0002);
    cyc(2'd0, 0, 0, 16'h0, 3'b110);
    expectReg("R4 ch1 ch2", 2'd0, 16'h000E);

    // R7 zero write without arm, and ones written
    cyc(2'd0, 0, 1, 16'h0000, '0);
    expectReg("R7 unarmed zero", 2'd0, 16'h000E);
    cyc(2'd0, 0, 1, 16'hFFFF, '0);
    expectReg("R7 ones", 2'd0, 16'h000E);

    // R6 arm then clear ch0; R10 others stay armed
    cyc(2'd0, 1, 0, 16'h0, '0);
    cyc(2'd0, 0, 1, 16'hFFFD, '0);
    expectReg("R6 clear bit1", 2'd0, 16'h000C);
    cyc(2'd0, 0, 1, 16'hFFFB, '0);
    expectReg("R10 bit2 still armed", 2'd0, 16'h0008);

    // R8 event between read and write
    cyc(2'd0, 1, 0, 16'h0, '0);
    cyc(2'd0, 0, 0, 16'h0, 3'b100);
    cyc(2'd0, 0, 1, 16'h0000, '0);
    expectReg("R8 flag kept", 2'd0, 16'h0008);
    cyc(2'd0, 0, 1, 16'h0000, '0);
    expectReg("R8 arm dropped", 2'd0, 16'h0008);
    cyc(2'd0, 1, 0, 16'h0, '0);
    cyc(2'd0, 0, 1, 16'h0000, '0);
    expectReg("R6 clear after rearm", 2'd0, 16'h0000);

    // R9 event and clearing write in the same cycle
    cyc(2'd0, 0, 0, 16'h0, 3'b001);
    cyc(2'd0, 1, 0, 16'h0, '0);
    cyc(2'd0, 0, 1, 16'h0000, 3'b001);
    expectReg("R9 set wins", 2'd0, 16'h0002);
    cyc(2'd0, 0, 1, 16'h0000, '0);
    expectReg("R9 arm dropped", 2'd0, 16'h0002);

    // R5 irq follows enabled flags only
    cyc(2'd1, 0, 1, 16'h0004, '0);
    expectReg("R5 polled disabled flag", 2'd0, 16'h0002);
    check("R5 irq low", 16'(irq), 16'h0);
    cyc(2'd0, 0, 0, 16'h0, 3'b010);
    expectReg("R5 both flags", 2'd0, 16'h0006);
    check("R5 irq high", 16'(irq), 16'h1);
    cyc(2'd0, 1, 0, 16'h0, '0);
    cyc(2'd0, 0, 1, 16'hFFFB, '0);
    expectReg("R5 enabled cleared", 2'd0, 16'h0002);
    check("R5 irq drops", 16'(irq), 16'h0);
    cyc(2'd0, 0, 1, 16'hFFFD, '0);
    expectReg("R10 neighbour armed", 2'd0, 16'h0000);

    // R11 register map
    cyc(2'd1, 0, 1, 16'hFFFF, '0);
    expectReg("R11 enable width", 2'd1, 16'h000F);
    cyc(2'd2, 0, 1, 16'h0ABC, '0);
    expectReg("R11 modulo rw", 2'd2, 16'h0ABC);
    look(2'd3, prev);
    cyc(2'd3, 0, 1, 16'h0000, '0);
    look(2'd3, v);
    check("R11 counter write ignored", v, prev + 16'd2);

    // R2 small terminal value
    doReset();
    cyc(2'd2, 0, 1, 16'd5, '0);
    look(2'd3, prev);
    loops = 0;
    while (prev != 16'd4 && loops < 20) begin
      look(2'd3, v);
      check("R2 step", v, (prev == 16'd5) ? 16'd0 : prev + 16'd1);
      prev = v;
      loops++;
    end
    expectReg("R2 no flag at terminal", 2'd0, 16'h0000);
    expectReg("R2 wrap to zero", 2'd3, 16'h0000);
    expectReg("R2 flag after wrap", 2'd0, 16'h0001);

    // R3 free run wrap
    doReset();
    v = '0;
    loops = 0;
    while (v != 16'hFFFE && loops < 70000) begin
      look(2'd3, v);
      loops++;
    end
    expectReg("R3 no flag at FFFF", 2'd0, 16'h0000);
    expectReg("R3 wrap to zero", 2'd3, 16'h0000);
    expectReg("R3 flag after wrap", 2'd0, 16'h0001);

    // randomized traffic against the reference
    doReset();
    cyc(2'd2, 0, 1, 16'd23, '0);
    for (int n = 0; n < 4000; n++) begin
      logic [1:0] a;
      logic r, w;
      logic [NCH-1:0] ev;
      a  = 2'($urandom % 4);
      r  = ($urandom % 3) == 0;
      w  = (($urandom % 4) == 0) && (a != 2'd2);
      ev = (($urandom % 8) == 0) ? NCH'($urandom % 8) : '0;
      cyc(a, r, w, 16'($urandom), ev);
      #1;
      case (a)
        2'd0: check("R6 random status", rdData, modelRead(a));
        2'd3: check("R2 random counter", rdData, modelRead(a));
        default: check("R11 random reg", rdData, modelRead(a));
      endcase
      check("R5 random irq", 16'(irq), 16'(|(mFlags & mEn)));
    end

    finishRun();
  end

endmodule